// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads translation entries from memory: first a directory entry, then, when needed, a page-table entry. A walk begins when `start` is pulsed while the block is idle. The directory is located by `dir_base`. All memory reads go through a single read port that uses a request/response handshake, and only one read is in flight at any time.

Each directory entry decides how the walk goes on. If the entry is not present, the walk ends in a fault. If its large-page flag is set, the entry maps a 4 MB frame and the walk ends after one read. Otherwise the entry points to a page table, and the page-table entry supplies a 4 KB frame. The walk ends with a one-cycle `done` pulse. `fault` is raised in the same cycle when the translation failed.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req_valid` are low. A `start` seen while idle captures `lin_addr` and `dir_base` and begins a walk in the next cycle. A `start` seen while busy is ignored and does not change the walk in progress.
- R2: The first read of a walk is at address {dir_base[31:12], lin_addr[31:22], 2'b00}. Bits 11:0 of `dir_base` are ignored.
- R3: When the directory entry has bit 0 (present) set and bit 7 (large page) clear, a second read is issued at {entry[31:12], lin_addr[21:12], 2'b00}.
- R4: When a present page-table entry (bit 0 set) is returned, the result is {pte[31:12], lin_addr[11:0]} and `fault` stays low.
- R5: When the directory entry has bit 0 and bit 7 set, no second read is issued. The result is {entry[31:22], lin_addr[21:0]}, and entry bits 21:12 are ignored.
- R6: When the directory entry has bit 0 clear, the walk ends with a fault after a single read, whatever the value of bit 7. `phys_addr` reads zero while `fault` is high.
- R7: When the page-table entry has bit 0 clear, the walk ends with a fault after two reads.
- R8: `done` is a single-cycle pulse. `fault` is high only together with `done`. `busy` is low in the cycle after `done`.
- R9: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` accepts the request. A response is taken only while its read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk when idle |
| lin_addr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Physical address of the page directory |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a page fault (with `done`) |
| phys_addr | output | 32 | Translated address, valid with `done` when no fault |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only after it has accepted a request and before the walker issues the next one. They also assume that a response is never sent while the walker is idle. The bench's memory responder holds to this by answering each accepted read exactly once, after a varying delay. It also varies how long it keeps `mem_req_ready` low. Entries are computed from the requested address, so the sweep over all 1024 directory indices reaches every entry kind. During odd-numbered walks the bench holds a conflicting `start` high to show that it is ignored.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW       = 32,
  parameter int OFF_W    = 12,
  parameter int PRES_BIT = 0,
  parameter int LARGE_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] lin_addr,
  input  logic [AW-1:0] dir_base,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] phys_addr
);
  localparam int IDX_W   = OFF_W - 2;
  localparam int LOW_W   = OFF_W + IDX_W;
  localparam int FRAME_W = AW - OFF_W;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT, S_FIN
  } state_t;

  state_t               state;
  logic [AW-1:0]        va_q;
  logic [FRAME_W-1:0]   base_q;
  logic [FRAME_W-1:0]   tbl_q;
  logic [AW-1:0]        phys_q;
  logic                 fault_q;

  assign mem_req_valid = (state == S_DREQ) || (state == S_TREQ);
  assign mem_req_addr  = (state == S_TREQ) ? {tbl_q, va_q[LOW_W-1:OFF_W], 2'b00}
                                           : {base_q, va_q[AW-1:LOW_W], 2'b00};
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign fault     = done && fault_q;
  assign phys_addr = phys_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      phys_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          va_q    <= lin_addr;
          base_q  <= dir_base[AW-1:OFF_W];
          fault_q <= 1'b0;
          phys_q  <= '0;
          state   <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) state <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[PRES_BIT]) begin
            fault_q <= 1'b1;
            phys_q  <= '0;
            state   <= S_FIN;
          end else if (mem_rsp_data[LARGE_BIT]) begin
            phys_q  <= {mem_rsp_data[AW-1:LOW_W], va_q[LOW_W-1:0]};
            state   <= S_FIN;
          end else begin
            tbl_q   <= mem_rsp_data[AW-1:OFF_W];
            state   <= S_TREQ;
          end
        end
        S_TREQ: if (mem_req_ready) state <= S_TWAIT;
        S_TWAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[PRES_BIT]) begin
            fault_q <= 1'b1;
            phys_q  <= '0;
          end else begin
            phys_q  <= {mem_rsp_data[AW-1:OFF_W], va_q[OFF_W-1:0]};
          end
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] lin_addr,
  input logic [AW-1:0] dir_base,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [AW-1:0] phys_addr
);
  localparam int LOW_W = 2 * OFF_W - 2;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !done)); // R1
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_req_valid)); // R1
  AST_DIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> mem_req_addr ==
      {$past(dir_base[AW-1:OFF_W]), $past(lin_addr[AW-1:LOW_W]), 2'b00}); // R2
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (phys_addr == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R8
  AST_FAULT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
endmodule

bind pt_walker pt_walker_checker #(.AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lin_addr(lin_addr), .dir_base(dir_base),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .busy(busy), .done(done), .fault(fault),
  .phys_addr(phys_addr)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] lin_addr = '0;
  logic [31:0] dir_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy, done, fault;
  logic [31:0] phys_addr;

  int checks = 0;
  int errors = 0;
  int dly = 0;
  logic [31:0] cur_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .lin_addr(lin_addr), .dir_base(dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .fault(fault),
    .phys_addr(phys_addr)
  );

  function automatic logic [31:0] pde_of(logic [9:0] i);
    case (i[1:0])
      2'd0:    return 32'h1234_50FE;
      2'd1:    return {i ^ 10'h2A5, 10'h3FF, 12'h081};
      default: return {10'h100, i, 12'h001};
    endcase
  endfunction

  function automatic logic [31:0] pte_of(logic [9:0] i, logic [9:0] t);
    if (t % 7 == 0) return 32'hABCD_E0FE;
    return {t, i ^ 10'h155, 12'h661};
  endfunction

  function automatic logic [31:0] mem_data(logic [31:0] a);
    if (a[31:12] == cur_base[31:12]) return pde_of(a[11:2]);
    return pte_of(a[21:12], a[11:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] exp_addr, input string req);
    chk(mem_req_valid == 1'b1, req, "request valid", {31'd0, mem_req_valid}, 32'd1);
    chk(mem_req_addr == exp_addr, req, "request address", mem_req_addr, exp_addr);
    repeat (dly % 3) @(negedge clk);
    chk(mem_req_addr == exp_addr, "R9", "held address", mem_req_addr, exp_addr);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    repeat ((dly / 3) % 3) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = mem_data(exp_addr);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
    dly++;
  endtask

  task automatic walk(input logic [31:0] lin, input logic [31:0] base, input bit interfere);
    logic [31:0] pde, pte, exp_phys, a2;
    bit exp_fault;
    pde = pde_of(lin[31:22]);
    cur_base = base;
    @(negedge clk);
    lin_addr = lin; dir_base = base; start = 1'b1;
    @(negedge clk);
    if (interfere) begin
      lin_addr = ~lin; dir_base = ~base;
    end else start = 1'b0;
    serve({base[31:12], lin[31:22], 2'b00}, "R2");
    if (!pde[0]) begin
      exp_fault = 1'b1; exp_phys = '0;
      chk(done && !mem_req_valid, "R6", "single-read fault", {30'd0, done, mem_req_valid}, 32'd2);
    end else if (pde[7]) begin
      exp_fault = 1'b0; exp_phys = {pde[31:22], lin[21:0]};
      chk(done && !mem_req_valid, "R5", "large page one read", {30'd0, done, mem_req_valid}, 32'd2);
    end else begin
      a2 = {pde[31:12], lin[21:12], 2'b00};
      serve(a2, "R3");
      pte = pte_of(lin[31:22], lin[21:12]);
      exp_fault = !pte[0];
      exp_phys = pte[0] ? {pte[31:12], lin[11:0]} : 32'd0;
    end
    chk(done == 1'b1, "R8", "done pulse", {31'd0, done}, 32'd1);
    chk(fault == exp_fault, exp_fault ? (pde[0] ? "R7" : "R6") : "R4", "fault flag",
        {31'd0, fault}, {31'd0, exp_fault});
    chk(phys_addr == exp_phys, pde[7] ? "R5" : "R4", interfere ? "phys (R1 start ignored)" : "phys",
        phys_addr, exp_phys);
    start = 1'b0;
    @(negedge clk);
    chk(!done && !busy && !fault, "R8", "back to idle", {29'd0, done, busy, fault}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req_valid, "R1", "reset state",
        {28'd0, busy, done, fault, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req_valid, "R1", "idle after reset", {30'd0, busy, mem_req_valid}, 32'd0);
    for (int i = 0; i < 1024; i++) begin
      logic [9:0]  ix, tx;
      logic [11:0] off;
      ix  = 10'(i);
      tx  = 10'((i * 37 + i / 4) % 1024);
      off = 12'((i * 2531) % 4096);
      walk({ix, tx, off}, 32'h0000_5000 | 32'((i * 3) & 12'hFFF), (i % 2) == 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule